// File: doc/BRIEF.md
# Update Strobe Generator

This block signals that fresh sensor output is available. Each update event from the sensor datapath produces one pulse on one of two general-purpose output lines. A 16-bit control register, written over a simple register bus, decides whether the strobe is on, which level counts as active, and which of the two lines carries it. A line that is not carrying the strobe passes its ordinary GPIO drive straight through from a separate input.

The pulse width is not a fixed clock count. An interval counter measures the clocks between the two most recent update events, and the pulse is held for a quarter of that interval. This keeps the active fraction of the waveform inside a bounded duty window whatever the update rate is. Polarity and line changes are held back until no pulse is in flight, so neither line shows a partial pulse.

Top module: `update_strobe_gen`

## Requirements
- R1: After reset the control register reads 0x0000 and both lines follow `gpio_in`.
- R2: Only control bits 2:0 are stored. Bits 15:3 always read back as zero, and writes to them have no effect.
- R3: While control bit 2 (enable) is 0, `line_out[i]` equals `gpio_in[i]` for both lines in every cycle, even when update events arrive.
- R4: Control bit 0 picks the strobe line: 0 selects `line_out[0]` and 1 selects `line_out[1]`. The other line follows its `gpio_in` bit.
- R5: Control bit 1 sets polarity: 1 gives an active-high pulse with a low idle level, and 0 gives an active-low pulse with a high idle level.
- R6: An update event sampled at a clock edge makes the strobe line active from that edge on. Every event gives exactly one pulse.
- R7: The pulse lasts max(floor(P/4), 1) clocks, where P is the number of clocks between this event and the one before it. The first event after reset gives a 1-clock pulse.
- R8: For update intervals of 8 clocks or more, the active fraction of the interval lies between 15% and 35%.
- R9: An event that arrives while a pulse is active ends that pulse, leaves the line at its idle level for one clock, and then starts a new pulse whose width comes from the new interval.
- R10: A change to enable, polarity or line select reaches the lines only once no pulse is active or pending. A pulse in progress finishes on its original line with its original polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 16 | Control register write data |
| reg_rdata | output | 16 | Control register read data |
| upd_evt | input | 1 | One-clock pulse for each output register update |
| gpio_in | input | 2 | Ordinary GPIO drive for each line |
| line_out | output | 2 | Line outputs (strobe or GPIO passthrough) |

## Verification
Two functions can land in the same cycle. A new update event can arrive while a pulse is still active, which is the restart of R9. A control write can land in the middle of a pulse, which is the deferral of R10. The bench provokes the first by raising a second event two clocks into a 4-clock pulse, and it expects the exact sample pattern active, active, idle, active, idle. It provokes the second by moving the strobe line partway through a pulse, and it expects the full pulse to finish on the old line before the new line takes over.

// File: rtl/strobe_pkg.sv
// Package: shared types for the update strobe generator.
// Assumes the enable, polarity and line-select fields sit in control bits 2:0
// in that order, so the packed struct can be cast straight from those bits.
package strobe_pkg;
    typedef struct packed {
        logic en;   // bit 2: strobe enable
        logic pol;  // bit 1: 1 = active high
        logic sel;  // bit 0: 1 = line 1, 0 = line 0
    } strobe_cfg_t;

    localparam int CFG_BITS  = 3;
    localparam int NUM_LINES = 2;
endpackage

// File: rtl/strobe_ctrl_reg.sv
// Module: strobe_ctrl_reg
// Holds the control register. Only the three configuration bits are stored;
// every other bit reads back as zero. Assumes a single-cycle write strobe.
module strobe_ctrl_reg
    import strobe_pkg::*;
#(
    parameter int REG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    output strobe_cfg_t      cfg
);
    localparam int PAD_W = REG_W - CFG_BITS;

    // Capture the configuration bits on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (wr_en) begin
            cfg <= strobe_cfg_t'(wr_data[CFG_BITS-1:0]);
        end
    end

    // Read data: the stored bits, zero above them.
    assign rd_data = {{PAD_W{1'b0}}, cfg};
endmodule

// File: rtl/interval_meter.sv
// Module: interval_meter
// Counts the clocks between update events and offers a pulse width equal to
// the current count shifted right by SHIFT, with a floor of one clock. Until a
// first event has been seen, the width offered is one clock.
// Assumes evt is a one-clock pulse. The counter saturates rather than wrapping.
module interval_meter #(
    parameter int CNT_W = 16,
    parameter int SHIFT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt,
    output logic [CNT_W-1:0] width_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt;
    logic             seen;
    logic [CNT_W-1:0] scaled;

    // Interval counter: restart on each event, otherwise count up and saturate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            seen <= 1'b0;
        end else if (evt) begin
            cnt  <= ONE;
            seen <= 1'b1;
        end else if (cnt != '1) begin
            cnt <= cnt + ONE;
        end
    end

    // Width for a pulse starting now: a fraction of the interval, at least one.
    always_comb begin
        scaled  = cnt >> SHIFT;
        width_o = (seen && (scaled != '0)) ? scaled : ONE;
    end
endmodule

// File: rtl/pulse_timer.sv
// Module: pulse_timer
// Produces the logical strobe (level independent). An event while idle starts
// a pulse of width_i clocks. An event during a pulse drops the strobe for one
// clock (pending) and then starts a fresh pulse with the newly offered width.
// Assumes width_i >= 1.
module pulse_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt,
    input  logic [CNT_W-1:0] width_i,
    output logic             active_o,
    output logic             pend_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] remain;
    logic [CNT_W-1:0] held_w;

    // Pulse sequencing: start, restart through the pending gap, count down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_o <= 1'b0;
            pend_o   <= 1'b0;
            remain   <= '0;
            held_w   <= '0;
        end else if (evt) begin
            if (active_o) begin
                active_o <= 1'b0;
                pend_o   <= 1'b1;
                held_w   <= width_i;
            end else begin
                active_o <= 1'b1;
                pend_o   <= 1'b0;
                remain   <= width_i;
            end
        end else if (pend_o) begin
            active_o <= 1'b1;
            pend_o   <= 1'b0;
            remain   <= held_w;
        end else if (active_o) begin
            if (remain <= ONE) begin
                active_o <= 1'b0;
            end else begin
                remain <= remain - ONE;
            end
        end
    end
endmodule

// File: rtl/update_strobe_gen.sv
// Module: update_strobe_gen (top)
// Turns update events into a strobe on one of two lines. The control register
// sets enable, polarity and line. The configuration actually in force is
// copied from the register only while no pulse is active or pending. Lines
// that are not carrying the strobe pass their GPIO input through.
// Assumes upd_evt is synchronous to clk and one clock wide.
module update_strobe_gen
    import strobe_pkg::*;
#(
    parameter int REG_W = 16,
    parameter int CNT_W = 16,
    parameter int SHIFT = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_we,
    input  logic [REG_W-1:0]     reg_wdata,
    output logic [REG_W-1:0]     reg_rdata,
    input  logic                 upd_evt,
    input  logic [NUM_LINES-1:0] gpio_in,
    output logic [NUM_LINES-1:0] line_out
);
    strobe_cfg_t      cfg_reg;
    strobe_cfg_t      cfg_eff;
    logic [CNT_W-1:0] pulse_w;
    logic             pulse_on;
    logic             pulse_pend;

    strobe_ctrl_reg #(.REG_W(REG_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_we),
        .wr_data (reg_wdata),
        .rd_data (reg_rdata),
        .cfg     (cfg_reg)
    );

    interval_meter #(.CNT_W(CNT_W), .SHIFT(SHIFT)) u_meter (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (upd_evt),
        .width_o (pulse_w)
    );

    pulse_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (upd_evt),
        .width_i  (pulse_w),
        .active_o (pulse_on),
        .pend_o   (pulse_pend)
    );

    // Take up a new configuration only at an idle point, so no pulse is cut short.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_eff <= '0;
        end else if (!pulse_on && !pulse_pend) begin
            cfg_eff <= cfg_reg;
        end
    end

    // Per-line output: the strobe level on the selected line, GPIO passthrough elsewhere.
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        localparam logic LINE_CODE = 1'(g);
        assign line_out[g] = (cfg_eff.en && (cfg_eff.sel == LINE_CODE))
                             ? (pulse_on ? cfg_eff.pol : ~cfg_eff.pol)
                             : gpio_in[g];
    end
endmodule

// File: rtl/strobe_checker.sv
// Module: strobe_checker
// Concurrent checks on the strobe generator, attached to the top with a bind.
// Assumes the bound names pulse_on, pulse_pend and cfg_eff exist in the top.
module strobe_checker #(
    parameter int REG_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             upd_evt,
    input logic [REG_W-1:0] reg_rdata,
    input logic             pulse_on,
    input logic             pulse_pend,
    input logic [2:0]       cfg_eff
);
    // R2: unused control bits never read back as ones.
    assert_unused_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[REG_W-1:3] == '0);

    // R6: an event seen while idle starts a pulse at once.
    assert_event_starts_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_evt && !pulse_on) |=> pulse_on);

    // R9: an event during a pulse forces one idle clock with a pending restart.
    assert_restart_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_evt && pulse_on) |=> (!pulse_on && pulse_pend));

    // R9: a pending restart always turns into a pulse on the next clock.
    assert_pend_resume_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_pend |=> pulse_on);

    // R10: the configuration in force stays still while a pulse is in flight.
    assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_on || pulse_pend) |=> $stable(cfg_eff));
endmodule

bind update_strobe_gen strobe_checker #(.REG_W(REG_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .upd_evt    (upd_evt),
    .reg_rdata  (reg_rdata),
    .pulse_on   (pulse_on),
    .pulse_pend (pulse_pend),
    .cfg_eff    (cfg_eff)
);

// File: tb/tb_update_strobe_gen.sv
// Directed bench for update_strobe_gen: one task per scenario, each checking itself.
module tb_update_strobe_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        upd_evt = 1'b0;
    logic [1:0]  gpio_in = '0;
    logic [1:0]  line_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    update_strobe_gen dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .upd_evt   (upd_evt),
        .gpio_in   (gpio_in),
        .line_out  (line_out)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [15:0] v);
        reg_we = 1'b1;
        reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    // Event train with period p. Counts active samples on line ln and checks
    // that the other line follows its GPIO input.
    task automatic train(input int p, input int n, input int ln, input logic act,
                         input int first_w, input string req);
        for (int k = 0; k < n; k++) begin
            int cnt = 0;
            int other_bad = 0;
            int expw;
            upd_evt = 1'b1;
            for (int i = 0; i < p; i++) begin
                @(negedge clk);
                if (i == 0) upd_evt = 1'b0;
                if (line_out[ln] == act) cnt++;
                if (line_out[1-ln] != gpio_in[1-ln]) other_bad++;
            end
            expw = (k == 0) ? first_w : (((p / 4) < 1) ? 1 : (p / 4));
            chk(cnt == expw, {req, " R7 width"}, cnt, expw);
            chk(other_bad == 0, "R4 unselected line follows gpio", other_bad, 0);
            if (p >= 8 && k > 0)
                chk((cnt * 100 >= 15 * p) && (cnt * 100 <= 35 * p),
                    "R8 duty window", cnt * 100 / p, 25);
        end
    endtask

    task automatic t_reset();
        do_reset();
        chk(reg_rdata == 16'h0000, "R1 reset register", reg_rdata, 0);
        gpio_in = 2'b01;
        @(negedge clk);
        chk(line_out == 2'b01, "R1 lines follow gpio", line_out, 1);
        gpio_in = 2'b10;
        @(negedge clk);
        chk(line_out == 2'b10, "R1 lines follow gpio", line_out, 2);
    endtask

    task automatic t_reg_bits();
        do_reset();
        wr(16'hFFFF);
        chk(reg_rdata == 16'h0007, "R2 only bits 2:0 kept", reg_rdata, 7);
        wr(16'hFFF8);
        chk(reg_rdata == 16'h0000, "R2 upper bits ignored", reg_rdata, 0);
        gpio_in = 2'b01;
        upd_evt = 1'b1;
        @(negedge clk);
        upd_evt = 1'b0;
        chk(line_out == 2'b01, "R2 upper bits do not enable", line_out, 1);
    endtask

    task automatic t_disabled();
        int bad = 0;
        do_reset();
        wr(16'h0003);
        for (int i = 0; i < 40; i++) begin
            gpio_in = 2'(i);
            upd_evt = (i % 5 == 0);
            @(negedge clk);
            if (line_out != gpio_in) bad++;
        end
        upd_evt = 1'b0;
        chk(bad == 0, "R3 disabled lines follow gpio", bad, 0);
    endtask

    task automatic t_line0_high();
        do_reset();
        gpio_in = 2'b11;
        wr(16'h0006);
        chk(line_out[0] == 1'b0, "R5 active-high idle level", line_out[0], 0);
        train(16, 3, 0, 1'b1, 1, "R6 line0 high");
    endtask

    task automatic t_line1_low();
        do_reset();
        gpio_in = 2'b00;
        wr(16'h0005);
        chk(line_out[1] == 1'b1, "R5 active-low idle level", line_out[1], 1);
        train(10, 3, 1, 1'b0, 1, "R4 line1 low");
    endtask

    task automatic t_duty();
        do_reset();
        gpio_in = 2'b10;
        wr(16'h0006);
        train(8, 3, 0, 1'b1, 1, "R8 p8");
        train(13, 2, 0, 1'b1, 2, "R8 p13");
        train(40, 2, 0, 1'b1, 3, "R8 p40");
    endtask

    task automatic t_restart();
        logic [5:0] seen;
        do_reset();
        gpio_in = 2'b00;
        wr(16'h0006);
        train(16, 2, 0, 1'b1, 1, "R9 setup");
        upd_evt = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            upd_evt = (i == 1);
            seen[i] = line_out[0];
        end
        upd_evt = 1'b0;
        chk(seen == 6'b001011, "R9 restart pattern", seen, 6'b001011);
    endtask

    task automatic t_cfg_defer();
        int hi = 0;
        int b_bad = 0;
        do_reset();
        gpio_in = 2'b10;
        wr(16'h0006);
        train(16, 1, 0, 1'b1, 1, "R10 setup");
        upd_evt = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            upd_evt = 1'b0;
            reg_we = (i == 1);
            reg_wdata = 16'h0007;
            if (line_out[0]) hi++;
            if (line_out[1] != 1'b1) b_bad++;
        end
        reg_we = 1'b0;
        chk(hi == 4, "R10 pulse finishes on old line", hi, 4);
        chk(b_bad == 0, "R10 new line untouched mid-pulse", b_bad, 0);
        @(negedge clk);
        chk(line_out == 2'b10, "R10 old line idle before switch", line_out, 2);
        @(negedge clk);
        chk(line_out == 2'b00, "R10 switch at idle point", line_out, 0);
        upd_evt = 1'b1;
        @(negedge clk);
        upd_evt = 1'b0;
        chk(line_out == 2'b10, "R4 pulse on line1", line_out, 2);
        repeat (20) @(negedge clk);
    endtask

    initial begin
        t_reset();
        t_reg_bits();
        t_disabled();
        t_line0_high();
        t_line1_low();
        t_duty();
        t_restart();
        t_cfg_defer();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end
endmodule